// File: doc/BRIEF.md
# Synchronous Clock Stop Gating

This block produces two groups of gated clock outputs from one reference clock that runs at twice the CPU clock rate. The first group is a set of CPU-rate clocks. The second group is a set of half-rate PCI clocks. There is also one free-running PCI-rate clock and a pair of auxiliary memory clocks. An internal two-bit divider makes both rates, so a PCI rising edge always falls on a CPU rising edge. Every output is a registered copy of its phase, so each output is a plain flop output.

Each gated group has its own asynchronous active-low stop pin. The block synchronizes each pin over two reference flops before using it. Stopping and restarting act only on the edge where a clock goes low, or on an edge where it stays low. A stopped clock therefore rests low, and the first high phase after a restart is always full width. Per-output enable bits come from a configuration register that resets to all ones, and they are applied at the same low-phase edges.

The mode strap changes how the stop pins are used. When it is high, the stop pins are ignored, and the two auxiliary outputs run at the CPU rate. A pad wrapper outside this block routes those outputs onto the pins that carry the stop inputs when the strap is low. After each restart, a hold counter keeps the group running for a minimum time before a new stop request is honoured.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every output is low. After release, every enabled output starts toggling within 8 reference cycles, with no stop requested.
- R2: Counting edges after reset release as n = 1, 2, 3 and so on: CPU and auxiliary outputs are high for one reference cycle and low for one. PCI and free-running PCI outputs are high for two and low for two.
- R3: CPU and auxiliary outputs rise only after odd edges n. Gated and free PCI outputs rise only after edges n with n mod 4 = 1, which is where the CPU outputs also rise.
- R4: With the strap low, after `stop_cpu_n` falls, each CPU output rises at most 2 more times and is then held low. The PCI and free PCI outputs keep their full rate.
- R5: After `stop_cpu_n` rises, the CPU outputs rise again within 8 reference cycles, which is 4 CPU periods.
- R6: With the strap low, after `stop_pci_n` falls, each gated PCI output rises at most once more and is then held low. The free PCI and CPU outputs keep their full rate.
- R7: After `stop_pci_n` rises, the first gated PCI rise comes together with the first or second free PCI rise. Every high phase of a gated PCI output is exactly two reference cycles long.
- R8: Once a group restarts, it keeps running for at least MIN_CPU_ON (100) CPU periods or MIN_PCI_ON (10) PCI periods, even if its stop pin falls again sooner. It then stops: 100 to 102 CPU rises, or 10 to 11 PCI rises.
- R9: Enable bit i of `cpu_en` or `pci_en` gates output i. A value of 0 holds that output low, and a value of 1 lets it run. Other outputs are not affected. A change takes effect only at a low phase, so it never shortens a high pulse.
- R10: With the strap high, both stop pins are ignored. Auxiliary output i then runs at the CPU rate when `aux_en[i]` is 1. With the strap low, the auxiliary outputs are held low.
- R11: The free PCI output ignores `stop_pci_n`. Only `pci_free_en` holds it low, and only when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock at twice the CPU rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_cpu_n | input | 1 | Asynchronous active-low CPU group stop request |
| stop_pci_n | input | 1 | Asynchronous active-low PCI group stop request |
| strap_mode | input | 1 | High: stop pins ignored, auxiliary clocks enabled |
| cpu_en | input | N_CPU | Per-output enables of the CPU group |
| pci_en | input | N_PCI | Per-output enables of the PCI group |
| pci_free_en | input | 1 | Enable of the free-running PCI output |
| aux_en | input | N_AUX | Per-output enables of the auxiliary clocks |
| cpu_clk | output | N_CPU | Gated CPU-rate clocks |
| pci_clk | output | N_PCI | Gated PCI-rate clocks |
| pci_free_clk | output | 1 | Free-running PCI-rate clock |
| aux_clk | output | N_AUX | Auxiliary CPU-rate clocks |

## Verification
A stop pin change passes through two synchronizer edges. It then waits for at most two more edges until the next low-going edge of its group. A restarted clock first rises one or two edges after that. So an off transition is due within four reference edges, and a first rising edge is due within seven. The bench drives its inputs just after a falling clock edge and samples just after falling edges. It counts rising edges over fixed windows that begin at least eight cycles after each stimulus. It checks the latency bounds as ranges of rising-edge counts, because the edge where the divider phase falls relative to the pin change is not fixed. The phase checks compare every rising edge with the number of edges since reset, taken modulo 2 or 4.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  // reference cycles per output period
  localparam int unsigned CPU_TICKS = 2;
  localparam int unsigned PCI_TICKS = 4;

  // width of a down-counter that must hold the value n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/cks_sync.sv
`timescale 1ns/1ps
module cks_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/cks_phase.sv
`timescale 1ns/1ps
module cks_phase (
  input  logic clk,
  input  logic rst_n,
  output logic cpu_ph_nxt,
  output logic pci_ph_nxt
);
  logic [1:0] div_q, div_d;

  always_comb begin
    div_d      = div_q + 2'd1;
    cpu_ph_nxt = div_d[0];
    pci_ph_nxt = div_d[0] ^ div_d[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 2'd0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/cks_gate.sv
`timescale 1ns/1ps
module cks_gate #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned HOLD  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_nxt,
  input  logic             stop_req,
  input  logic [WIDTH-1:0] en,
  output logic [WIDTH-1:0] clk_out
);
  localparam int unsigned CW = clkstop_pkg::cnt_bits(HOLD);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic             upd, turn_on;
  logic             run_q, run_d;
  logic [CW-1:0]    hold_q, hold_d;
  logic [WIDTH-1:0] gate_q, gate_d;
  logic [WIDTH-1:0] out_q, out_d;

  // updates only where the output goes or stays low
  always_comb begin
    upd   = ~ph_nxt;
    run_d = run_q;
    if (upd) begin
      if (!run_q && !stop_req)
        run_d = 1'b1;
      else if (run_q && stop_req && hold_q == '0)
        run_d = 1'b0;
    end
    turn_on = run_d & ~run_q;
    hold_d  = hold_q;
    if (turn_on)
      hold_d = HOLD_V;
    else if (hold_q != '0)
      hold_d = hold_q - ONE_V;
    gate_d = en & {WIDTH{run_d}};
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      out_d[i] = ph_nxt & (upd ? gate_d[i] : gate_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      run_q  <= run_d;
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   gate_q <= '0;
    else if (upd) gate_q <= gate_d;
  end

  assign clk_out = out_q;
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int unsigned N_CPU      = 4,
  parameter int unsigned N_PCI      = 6,
  parameter int unsigned N_AUX      = 2,
  parameter int unsigned MIN_CPU_ON = 100,
  parameter int unsigned MIN_PCI_ON = 10
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             stop_cpu_n,
  input  logic             stop_pci_n,
  input  logic             strap_mode,
  input  logic [N_CPU-1:0] cpu_en,
  input  logic [N_PCI-1:0] pci_en,
  input  logic             pci_free_en,
  input  logic [N_AUX-1:0] aux_en,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_free_clk,
  output logic [N_AUX-1:0] aux_clk
);
  localparam int unsigned CPU_HOLD = clkstop_pkg::CPU_TICKS * MIN_CPU_ON;
  localparam int unsigned PCI_HOLD = clkstop_pkg::PCI_TICKS * MIN_PCI_ON;

  logic cpu_pin_s, pci_pin_s;
  logic cpu_ph_nxt, pci_ph_nxt;
  logic cpu_stop, pci_stop, aux_off;
  logic [0:0] free_out;

  cks_sync #(.RST_VAL(1'b1)) u_sync_cpu (
    .clk(clk_ref), .rst_n(rst_n), .d(stop_cpu_n), .q(cpu_pin_s));
  cks_sync #(.RST_VAL(1'b1)) u_sync_pci (
    .clk(clk_ref), .rst_n(rst_n), .d(stop_pci_n), .q(pci_pin_s));

  cks_phase u_phase (
    .clk(clk_ref), .rst_n(rst_n),
    .cpu_ph_nxt(cpu_ph_nxt), .pci_ph_nxt(pci_ph_nxt));

  always_comb begin
    cpu_stop = ~cpu_pin_s & ~strap_mode;
    pci_stop = ~pci_pin_s & ~strap_mode;
    aux_off  = ~strap_mode;
  end

  cks_gate #(.WIDTH(N_CPU), .HOLD(CPU_HOLD)) u_cpu (
    .clk(clk_ref), .rst_n(rst_n), .ph_nxt(cpu_ph_nxt),
    .stop_req(cpu_stop), .en(cpu_en), .clk_out(cpu_clk));

  cks_gate #(.WIDTH(N_PCI), .HOLD(PCI_HOLD)) u_pci (
    .clk(clk_ref), .rst_n(rst_n), .ph_nxt(pci_ph_nxt),
    .stop_req(pci_stop), .en(pci_en), .clk_out(pci_clk));

  cks_gate #(.WIDTH(1), .HOLD(0)) u_free (
    .clk(clk_ref), .rst_n(rst_n), .ph_nxt(pci_ph_nxt),
    .stop_req(1'b0), .en(pci_free_en), .clk_out(free_out));

  cks_gate #(.WIDTH(N_AUX), .HOLD(0)) u_aux (
    .clk(clk_ref), .rst_n(rst_n), .ph_nxt(cpu_ph_nxt),
    .stop_req(aux_off), .en(aux_en), .clk_out(aux_clk));

  assign pci_free_clk = free_out[0];
endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/1ps
module clkstop_gate_chk #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_PCI = 6,
  parameter int unsigned N_AUX = 2
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic [N_CPU-1:0] cpu_en,
  input logic             pci_free_en,
  input logic [N_CPU-1:0] cpu_clk,
  input logic [N_PCI-1:0] pci_clk,
  input logic             pci_free_clk,
  input logic [N_AUX-1:0] aux_clk
);
  always @(posedge clk_ref) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (cpu_clk == '0 && pci_clk == '0 && !pci_free_clk && aux_clk == '0); // R1
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_CPU; gi++) begin : g_cpu
      AST_CPU_ONE_TICK_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cpu_clk[gi] |=> !cpu_clk[gi]); // R2
      AST_CPU_EN_HOLDS_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($past(!cpu_en[gi]) && $past(!cpu_en[gi], 2)) |-> !cpu_clk[gi]); // R9
    end
    for (gi = 0; gi < N_PCI; gi++) begin : g_pci
      AST_PCI_FULL_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $fell(pci_clk[gi]) |-> $past(pci_clk[gi], 2)); // R7
      AST_PCI_ALIGNED: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($rose(pci_clk[gi]) && $past(pci_free_en) && $past(pci_free_en, 2)) |-> $rose(pci_free_clk)); // R3
    end
  endgenerate
endmodule

bind clkstop_gate clkstop_gate_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_AUX(N_AUX)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .cpu_en(cpu_en), .pci_free_en(pci_free_en),
  .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free_clk(pci_free_clk), .aux_clk(aux_clk));

// File: tb/clkstop_gate_test.sv
`timescale 1ns/1ps
module clkstop_gate_test;
  localparam int N_CPU = 4;
  localparam int N_PCI = 6;
  localparam int N_AUX = 2;

  logic clk, rst_n, stop_cpu_n, stop_pci_n, strap_mode, pci_free_en;
  logic [N_CPU-1:0] cpu_en, cpu_clk, cpu_p;
  logic [N_PCI-1:0] pci_en, pci_clk, pci_p;
  logic [N_AUX-1:0] aux_en, aux_clk, aux_p;
  logic pci_free_clk, free_p;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int tick = 0, runt = 0, misphase = 0;
  int cpu_r[N_CPU], pci_r[N_PCI], aux_r[N_AUX];
  int free_r = 0;
  int hl[N_PCI+1];

  clkstop_gate uut (
    .clk_ref(clk), .rst_n(rst_n), .stop_cpu_n(stop_cpu_n), .stop_pci_n(stop_pci_n),
    .strap_mode(strap_mode), .cpu_en(cpu_en), .pci_en(pci_en), .pci_free_en(pci_free_en),
    .aux_en(aux_en), .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free_clk(pci_free_clk),
    .aux_clk(aux_clk));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: rising-edge counts, phase (R3) and high-width (R7, R9) checks
  initial begin
    for (int i = 0; i < N_CPU; i++) cpu_r[i] = 0;
    for (int i = 0; i < N_PCI; i++) pci_r[i] = 0;
    for (int i = 0; i < N_AUX; i++) aux_r[i] = 0;
    for (int i = 0; i <= N_PCI; i++) hl[i] = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tick = tick + 1;
      for (int i = 0; i < N_CPU; i++)
        if (cpu_clk[i] && !cpu_p[i]) begin
          cpu_r[i] = cpu_r[i] + 1;
          if (tick % 2 != 1) misphase = misphase + 1;
        end
      for (int i = 0; i < N_AUX; i++)
        if (aux_clk[i] && !aux_p[i]) begin
          aux_r[i] = aux_r[i] + 1;
          if (tick % 2 != 1) misphase = misphase + 1;
        end
      for (int i = 0; i <= N_PCI; i++) begin
        logic v, pv;
        v  = (i == N_PCI) ? pci_free_clk : pci_clk[i];
        pv = (i == N_PCI) ? free_p : pci_p[i];
        if (v && !pv) begin
          if (i == N_PCI) free_r = free_r + 1;
          else pci_r[i] = pci_r[i] + 1;
          if (tick % 4 != 1) misphase = misphase + 1;
        end
        if (v) hl[i] = hl[i] + 1;
        else begin
          if (hl[i] != 0 && hl[i] != 2) runt = runt + 1;
          hl[i] = 0;
        end
      end
    end
    cpu_p = cpu_clk; pci_p = pci_clk; aux_p = aux_clk; free_p = pci_free_clk;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // counts rises of every output over a window of n cycles
  task automatic window(input int n, output int c[N_CPU], output int p[N_PCI],
                        output int f, output int a[N_AUX]);
    int c0[N_CPU], p0[N_PCI], a0[N_AUX], f0;
    c0 = cpu_r; p0 = pci_r; a0 = aux_r; f0 = free_r;
    wt(n);
    for (int i = 0; i < N_CPU; i++) c[i] = cpu_r[i] - c0[i];
    for (int i = 0; i < N_PCI; i++) p[i] = pci_r[i] - p0[i];
    for (int i = 0; i < N_AUX; i++) a[i] = aux_r[i] - a0[i];
    f = free_r - f0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int c[N_CPU], p[N_PCI], a[N_AUX], f, n, f0, s;
    rst_n = 1'b1; stop_cpu_n = 1'b1; stop_pci_n = 1'b1; strap_mode = 1'b0;
    cpu_en = '1; pci_en = '1; pci_free_en = 1'b1; aux_en = '1;
    #1 rst_n = 1'b0;
    wt(3);
    chk_eq("R1", "outputs in reset", int'({cpu_clk, pci_clk, pci_free_clk, aux_clk}), 0);
    rst_n = 1'b1;
    wt(8);

    // R2 rates, R10 aux low with strap low
    window(40, c, p, f, a);
    for (int i = 0; i < N_CPU; i++) chk_eq("R2", $sformatf("cpu%0d rises", i), c[i], 20);
    for (int i = 0; i < N_PCI; i++) chk_eq("R2", $sformatf("pci%0d rises", i), p[i], 10);
    chk_eq("R2", "free rises", f, 10);
    chk_eq("R10", "aux0 rises strap low", a[0], 0);

    // R4 CPU stop
    stop_cpu_n = 1'b0;
    window(8, c, p, f, a);
    for (int i = 0; i < N_CPU; i++) chk_rng("R4", $sformatf("cpu%0d rises after stop", i), c[i], 0, 2);
    window(20, c, p, f, a);
    chk_eq("R4", "cpu rises while stopped", c[0] + c[1] + c[2] + c[3], 0);
    chk_eq("R4", "cpu level while stopped", int'(cpu_clk), 0);
    chk_eq("R4", "pci0 rises during cpu stop", p[0], 5);
    chk_eq("R4", "free rises during cpu stop", f, 5);

    // R5 CPU restart
    stop_cpu_n = 1'b1;
    n = 0;
    while (!cpu_clk[0] && n < 20) begin wt(1); n++; end
    chk_rng("R5", "cycles to first cpu rise", n, 1, 8);
    chk_eq("R5", "all cpu outputs restart together", int'(cpu_clk), 15);
    wt(220);

    // R6 PCI stop
    stop_pci_n = 1'b0;
    window(8, c, p, f, a);
    for (int i = 0; i < N_PCI; i++) chk_rng("R6", $sformatf("pci%0d rises after stop", i), p[i], 0, 1);
    window(20, c, p, f, a);
    chk_eq("R6", "pci0 rises while stopped", p[0], 0);
    chk_eq("R6", "pci level while stopped", int'(pci_clk), 0);
    chk_eq("R11", "free rises during pci stop", f, 5);
    chk_eq("R6", "cpu0 rises during pci stop", c[0], 10);

    // R7 PCI restart
    f0 = free_r;
    stop_pci_n = 1'b1;
    n = 0;
    while (!pci_clk[0] && n < 20) begin wt(1); n++; end
    chk_rng("R7", "free rises up to first pci rise", free_r - f0, 1, 2);
    wt(60);

    // R8 minimum run time, CPU group
    stop_cpu_n = 1'b0;
    wt(20);
    s = cpu_r[0];
    stop_cpu_n = 1'b1;
    wt(10);
    stop_cpu_n = 1'b0;
    wt(260);
    chk_rng("R8", "cpu rises in minimum run", cpu_r[0] - s, 100, 102);
    chk_eq("R8", "cpu low after minimum run", int'(cpu_clk), 0);
    stop_cpu_n = 1'b1;
    wt(220);

    // R8 minimum run time, PCI group
    stop_pci_n = 1'b0;
    wt(20);
    s = pci_r[0];
    stop_pci_n = 1'b1;
    wt(6);
    stop_pci_n = 1'b0;
    wt(80);
    chk_rng("R8", "pci rises in minimum run", pci_r[0] - s, 10, 11);
    chk_eq("R8", "pci low after minimum run", int'(pci_clk), 0);
    stop_pci_n = 1'b1;
    wt(60);

    // R9 / R11 enables
    cpu_en = 4'b1101; pci_en = 6'b110111; pci_free_en = 1'b0;
    wt(8);
    window(20, c, p, f, a);
    chk_eq("R9", "cpu1 rises disabled", c[1], 0);
    chk_eq("R9", "cpu0 rises enabled", c[0], 10);
    chk_eq("R9", "pci3 rises disabled", p[3], 0);
    chk_eq("R9", "pci2 rises enabled", p[2], 5);
    chk_eq("R11", "free rises disabled", f, 0);
    for (int k = 0; k < 12; k++) begin
      repeat (k % 3 + 1) @(negedge clk);
      #1;
      pci_en = pci_en ^ 6'((k * 7 + 1) % 64);
      pci_free_en = k[0];
    end
    cpu_en = '1; pci_en = '1; pci_free_en = 1'b1;
    wt(8);
    window(20, c, p, f, a);
    for (int i = 0; i < N_PCI; i++) chk_eq("R9", $sformatf("pci%0d rises re-enabled", i), p[i], 5);
    chk_eq("R9", "cpu1 rises re-enabled", c[1], 10);

    // R10 strap high
    strap_mode = 1'b1; stop_cpu_n = 1'b0; stop_pci_n = 1'b0;
    wt(8);
    window(20, c, p, f, a);
    chk_eq("R10", "cpu0 rises stop ignored", c[0], 10);
    chk_eq("R10", "pci0 rises stop ignored", p[0], 5);
    chk_eq("R10", "aux0 rises", a[0], 10);
    chk_eq("R10", "aux1 rises", a[1], 10);
    aux_en = 2'b01;
    wt(8);
    window(20, c, p, f, a);
    chk_eq("R10", "aux1 rises disabled", a[1], 0);
    chk_eq("R10", "aux0 rises enabled", a[0], 10);
    stop_cpu_n = 1'b1; stop_pci_n = 1'b1;
    wt(4);
    strap_mode = 1'b0;
    wt(8);
    window(20, c, p, f, a);
    chk_eq("R10", "aux0 rises strap low again", a[0], 0);
    chk_eq("R10", "cpu0 rises strap low again", c[0], 10);

    chk_eq("R3", "rises off their phase", misphase, 0);
    chk_eq("R7", "short high pulses", runt, 0);
    done = 1;
    summary();
  end
endmodule